// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two 16-bit unsigned operands and returns the full 32-bit product. It is built as a hierarchy of multiplier levels. The smallest level is a 2x2 cell that forms the product column by column. One column is the vertical pair of low bits. The next is the sum of the two crosswise terms. The last is the vertical pair of high bits plus the carry from the crosswise column.

Each wider level (4x4, 8x8, 16x16) splits both operands into halves and forms four half-width sub-products: low×low, low×high, high×low and high×high. A fixed adder set merges them:

- The first full-width adder sums the two cross sub-products.
- The second full-width adder adds that sum to the high half of low×low joined with the low half of high×high.
- A half adder merges the carries from the two full-width adders.
- A half-width adder adds the merged carry into the upper half of high×high.

Each level is its own module, so it can be verified on its own.

The top can register its result. When `REG_OUT` is 1, the product is captured on a rising clock edge at which `in_valid` is high, and `out_valid` rises for the following cycle. When `REG_OUT` is 0, the path is purely combinational and `out_valid` follows `in_valid`.

Top module: `vcw_mult_top`

## Requirements
- R1: The 2x2 cell gives the exact 4-bit product for all 16 operand pairs.
- R2: The 4x4 level gives the exact 8-bit product for all 256 operand pairs.
- R3: The 8x8 level gives the exact 16-bit product for any operand pair.
- R4: The top gives the exact 32-bit unsigned product of `a` and `b`. For 0xFFFF times 0xFFFF the product is 0xFFFE0001.
- R5: If either operand is zero, the product is zero. If both operands have their upper 8 bits clear, product bits [31:16] are zero.
- R6: With `REG_OUT`=1, a rising edge with `in_valid`=1 loads the product of the current operands. At that same edge `out_valid` becomes 1, so it is high in the following cycle. An edge with `in_valid`=0 clears `out_valid`.
- R7: With `REG_OUT`=1, operand changes while `in_valid`=0 have no effect on `product`.
- R8: While `rst_n`=0, `product` is 0 and `out_valid` is 0.
- R9: With `REG_OUT`=0, `product` equals `a*b` combinationally and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands are valid; enables capture |
| a | input | 16 | Multiplicand, unsigned |
| b | input | 16 | Multiplier, unsigned |
| product | output | 32 | Unsigned product |
| out_valid | output | 1 | Product holds a captured result |

## Verification
The 2x2 and 4x4 levels are driven with every operand pair. This separates a wrong cross-term sum from a lost column carry. The 8x8 level and the top are driven with random operands and with corner values:

- zero;
- one;
- all ones;
- single high bits;
- alternating bit patterns.

Corner values with many ones make both full-width adders carry at once. That case exposes an error in the half-adder carry merge, which random values rarely reach. Operand changes with `in_valid` low show whether the register holds its value. A second instance with no register shows whether the combinational variant is correct.

// File: rtl/vcw_pkg.sv
package vcw_pkg;
    localparam int OP_W   = 16;
    localparam int PROD_W = 2 * OP_W;

    typedef struct packed {
        logic [PROD_W-1:0] product;
        logic              valid;
    } vcw_out_t;
endpackage

// File: rtl/vcw_cell2.sv
module vcw_cell2 (
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [3:0] p
);
    logic cross_lo, cross_hi, mid_c, top_v;

    always_comb begin
        cross_lo = x[1] & y[0];
        cross_hi = x[0] & y[1];
        mid_c    = cross_lo & cross_hi;
        top_v    = x[1] & y[1];
        p[0]     = x[0] & y[0];
        p[1]     = cross_lo ^ cross_hi;
        p[2]     = top_v ^ mid_c;
        p[3]     = top_v & mid_c;
    end
endmodule

// File: rtl/vcw_combine.sv
module vcw_combine #(
    parameter int N = 4
) (
    input  logic [N-1:0]   ll,
    input  logic [N-1:0]   lh,
    input  logic [N-1:0]   hl,
    input  logic [N-1:0]   hh,
    output logic [2*N-1:0] p
);
    localparam int H = N / 2;

    logic [N:0]   cross_sum;
    logic [N:0]   mid_sum;
    logic         ha_s, ha_c;
    logic [H-1:0] carry_in;
    logic [H-1:0] top;

    always_comb begin
        cross_sum     = {1'b0, lh} + {1'b0, hl};
        mid_sum       = {1'b0, cross_sum[N-1:0]} + {1'b0, hh[H-1:0], ll[N-1:H]};
        ha_s          = cross_sum[N] ^ mid_sum[N];
        ha_c          = cross_sum[N] & mid_sum[N];
        carry_in      = '0;
        carry_in[1:0] = {ha_c, ha_s};
        top           = hh[N-1:H] + carry_in;
        p             = {top, mid_sum[N-1:0], ll[H-1:0]};
    end
endmodule

// File: rtl/vcw_mul4.sv
module vcw_mul4 (
    input  logic [3:0] x,
    input  logic [3:0] y,
    output logic [7:0] p
);
    logic [3:0] sub [4];

    for (genvar q = 0; q < 4; q++) begin : g_quad
        vcw_cell2 u_cell (
            .x (q[1] ? x[3:2] : x[1:0]),
            .y (q[0] ? y[3:2] : y[1:0]),
            .p (sub[q])
        );
    end

    vcw_combine #(.N(4)) u_comb (
        .ll (sub[0]), .lh (sub[1]), .hl (sub[2]), .hh (sub[3]), .p (p)
    );
endmodule

// File: rtl/vcw_mul8.sv
module vcw_mul8 (
    input  logic [7:0]  x,
    input  logic [7:0]  y,
    output logic [15:0] p
);
    logic [7:0] sub [4];

    for (genvar q = 0; q < 4; q++) begin : g_quad
        vcw_mul4 u_m4 (
            .x (q[1] ? x[7:4] : x[3:0]),
            .y (q[0] ? y[7:4] : y[3:0]),
            .p (sub[q])
        );
    end

    vcw_combine #(.N(8)) u_comb (
        .ll (sub[0]), .lh (sub[1]), .hl (sub[2]), .hh (sub[3]), .p (p)
    );
endmodule

// File: rtl/vcw_mul16.sv
module vcw_mul16 (
    input  logic [15:0] x,
    input  logic [15:0] y,
    output logic [31:0] p
);
    logic [15:0] sub [4];

    for (genvar q = 0; q < 4; q++) begin : g_quad
        vcw_mul8 u_m8 (
            .x (q[1] ? x[15:8] : x[7:0]),
            .y (q[0] ? y[15:8] : y[7:0]),
            .p (sub[q])
        );
    end

    vcw_combine #(.N(16)) u_comb (
        .ll (sub[0]), .lh (sub[1]), .hl (sub[2]), .hh (sub[3]), .p (p)
    );
endmodule

// File: rtl/vcw_mult_top.sv
module vcw_mult_top
    import vcw_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [PROD_W-1:0] product,
    output logic              out_valid
);
    logic [PROD_W-1:0] raw;

    vcw_mul16 u_core (.x(a), .y(b), .p(raw));

    if (REG_OUT) begin : g_reg
        vcw_out_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.product = raw;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign product   = st_q.product;
        assign out_valid = st_q.valid;
    end else begin : g_comb
        assign product   = raw;
        assign out_valid = in_valid;
    end
endmodule

// File: rtl/vcw_mult_chk.sv
module vcw_mult_chk
    import vcw_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   a,
    input logic [OP_W-1:0]   b,
    input logic [PROD_W-1:0] product,
    input logic              out_valid
);
    logic [PROD_W-1:0] ref_now;
    assign ref_now = PROD_W'(a) * PROD_W'(b);

    if (REG_OUT) begin : g_reg_chk
        // R6
        a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R6
        a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(in_valid));
        // R4
        a_r4_exact: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> product == $past(ref_now));
        // R7
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(product));
        // R5
        a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (a == '0 || b == '0)) |=> product == '0);
    end else begin : g_comb_chk
        // R9
        a_r9_comb_exact: assert property (@(posedge clk) disable iff (!rst_n)
            product == ref_now);
        // R9
        a_r9_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
        // R5
        a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |-> product == '0);
        // R5
        a_r5_narrow: assert property (@(posedge clk) disable iff (!rst_n)
            (a[OP_W-1:OP_W/2] == '0 && b[OP_W-1:OP_W/2] == '0)
                |-> product[PROD_W-1:OP_W] == '0);
    end
endmodule

bind vcw_mult_top vcw_mult_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .product   (product),
    .out_valid (out_valid)
);

// File: tb/tb_vcw_mult_top.sv
module tb_vcw_mult_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] a = '0, b = '0;
    logic [31:0] product, product_c;
    logic        out_valid, out_valid_c;

    logic [1:0]  c2x, c2y;  logic [3:0]  c2p;
    logic [3:0]  m4x, m4y;  logic [7:0]  m4p;
    logic [7:0]  m8x, m8y;  logic [15:0] m8p;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vcw_mult_top #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .product(product), .out_valid(out_valid));
    vcw_mult_top #(.REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .product(product_c), .out_valid(out_valid_c));
    vcw_cell2 u_c2 (.x(c2x), .y(c2y), .p(c2p));
    vcw_mul4  u_m4 (.x(m4x), .y(m4y), .p(m4p));
    vcw_mul8  u_m8 (.x(m8x), .y(m8y), .p(m8p));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Expected register contents, kept by the bench
    logic [31:0] exp_prod = '0;
    logic        exp_vld  = 1'b0;

    // One clock of stimulus: drive at negedge, model the edge, compare after it
    task automatic step(input logic v, input logic [15:0] x, input logic [15:0] y, input string req);
        @(negedge clk);
        in_valid = v; a = x; b = y;
        #1;
        check("R9", product_c, 32'(x) * 32'(y));
        check("R9", {31'd0, out_valid_c}, {31'd0, v});
        @(posedge clk);
        if (v) exp_prod = 32'(x) * 32'(y);
        exp_vld = v;
        #2;
        check(req, product, exp_prod);
        check("R6", {31'd0, out_valid}, {31'd0, exp_vld});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [15:0] corners [10];
        corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h00FF,
                    16'hFF00, 16'hAAAA, 16'h5555, 16'h7FFF, 16'h0100};

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8", product, 32'd0);
        check("R8", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;

        // R1: exhaustive base cell
        for (int i = 0; i < 16; i++) begin
            c2x = i[3:2]; c2y = i[1:0]; #1;
            check("R1", 32'(c2p), 32'(c2x) * 32'(c2y));
        end
        // R2: exhaustive 4x4 level
        for (int i = 0; i < 256; i++) begin
            m4x = i[7:4]; m4y = i[3:0]; #1;
            check("R2", 32'(m4p), 32'(m4x) * 32'(m4y));
        end
        // R3: 8x8 level, corners and random
        for (int i = 0; i < 2000; i++) begin
            m8x = (i < 16) ? 8'hFF - 8'(i) : 8'($urandom);
            m8y = (i < 16) ? 8'hFF : 8'($urandom);
            #1;
            check("R3", 32'(m8p), 32'(m8x) * 32'(m8y));
        end

        // R4: all ones
        step(1'b1, 16'hFFFF, 16'hFFFF, "R4");
        check("R4", product, 32'hFFFE0001);
        // R4: corner pairs
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                step(1'b1, corners[i], corners[j], "R4");
        // R5: zero operand and narrow operands
        step(1'b1, 16'h0000, 16'hBEEF, "R5");
        check("R5", product, 32'd0);
        step(1'b1, 16'h00FF, 16'h00FF, "R5");
        check("R5", {16'd0, product[31:16]}, 32'd0);
        // R7: operands change with in_valid low, product must hold
        step(1'b1, 16'h1234, 16'h5678, "R6");
        for (int k = 0; k < 5; k++)
            step(1'b0, 16'($urandom), 16'($urandom), "R7");
        check("R7", product, 32'h1234 * 32'h5678);
        // R4/R6: random stream with mixed valid
        for (int k = 0; k < 3000; k++)
            step(1'($urandom_range(0, 3) != 0), 16'($urandom), 16'($urandom), "R4");

        finish_run();
    end
endmodule